// File: doc/BRIEF.md
# Sub-Sleep Power-Mode Controller

This block sits beside the processor core of a small microcontroller and decides what happens when the core executes its sleep instruction. Three configuration bits are compared against one fixed combination. When they match, the controller enters a low-power sub-sleep mode. In that mode the core clock and most peripheral clocks are gated off. A fixed subset of peripherals keeps its clock: the timers, both watchdogs and the display driver. Nothing held in the core, the RAM, the ports or the peripherals is reset on entry. The one exception is the analog-to-digital converter, whose clock is forced off and whose state is reported as lost.

Sub-sleep ends on any of three events:
- An interrupt that is allowed to wake the part. An external request line needs its enable bit set. A peripheral request needs its enable bit set and the core mask clear. The controller then returns to active mode and pulses a wake strobe that starts interrupt exception processing.
- Assertion of the reset pin.
- A low level on the standby pin. This overrides everything else and moves the controller into hardware standby, with every clock gated. Hardware standby is left only through a reset while the standby pin is high.

Top module: `subslp_ctrl`

## Requirements
- R1: With `mode` active (code 2'b00) and `standby_req_n` high, a `sleep_strobe` cycle whose configuration bits are `cfg_stdby_sel`=0, `cfg_lowspd_on`=1 and `cfg_wdt_subclk`=1 moves `mode` to sub-sleep (code 2'b01) at the next clock edge.
- R2: A `sleep_strobe` in active mode with any other combination of the three bits leaves `mode` active. It raises `sleep_reject` for exactly one cycle, starting at the next edge.
- R3: In sub-sleep, `cpu_clk_en` and `adc_clk_en` are 0. `periph_clk_en` equals the `KEEP_MASK` parameter, whose set bits mark the always-running modules.
- R4: In active mode, every clock enable is 1 and `adc_retained` is 1. In any other mode, `adc_retained` is 0.
- R5: An external request `ext_req[i]` ends sub-sleep only when `ext_en[i]` is 1.
- R6: A peripheral request `int_req[i]` ends sub-sleep only when `int_en[i]` is 1 and `cpu_mask` is 0.
- R7: A qualified wake request in sub-sleep returns `mode` to active at the next edge. `wake_pulse` is high for exactly that one cycle, which is the same cycle in which `cpu_clk_en` returns to 1.
- R8: `standby_req_n` low at a clock edge moves `mode` to hardware standby (code 2'b10) from any mode, even when a wake request is present. In hardware standby every clock enable is 0.
- R9: Hardware standby persists while `rst_n` stays high, whatever the other inputs do. Asserting `rst_n` low with `standby_req_n` high returns `mode` to active, with no `wake_pulse`.
- R10: `rst_n` low asynchronously puts `mode` in active with all clock enables on and both pulse outputs low.
- R11: `sleep_strobe` has no effect outside active mode. It does not change `mode` and does not raise `sleep_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| standby_req_n | input | 1 | Standby pin, low requests hardware standby |
| sleep_strobe | input | 1 | One-cycle strobe from the sleep instruction |
| cfg_stdby_sel | input | 1 | Software-standby select bit |
| cfg_lowspd_on | input | 1 | Low-speed-on bit |
| cfg_wdt_subclk | input | 1 | Watchdog prescaler sub-clock select bit |
| ext_req | input | N_EXT | External request lines |
| ext_en | input | N_EXT | Enable or pin-function bits of the external lines |
| int_req | input | N_INT | Peripheral interrupt requests |
| int_en | input | N_INT | Peripheral interrupt enable bits |
| cpu_mask | input | 1 | Core interrupt mask, 1 blocks peripheral wake |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| adc_clk_en | output | 1 | A/D converter clock enable |
| adc_retained | output | 1 | 1 while A/D state is valid |
| wake_pulse | output | 1 | One-cycle interrupt-start strobe on wake |
| sleep_reject | output | 1 | One-cycle strobe when a sleep did not enter sub-sleep |
| mode | output | 2 | Current mode: 00 active, 01 sub-sleep, 10 hardware standby |

## Verification
All the block's state sits in one mode register, and every output is decoded from it or registered beside it. A wrong next-state therefore shows on `mode` and on the clock enables one edge after the stimulus. A mis-qualified wake source shows in that same cycle: the mode either leaves sub-sleep when it should not or stays when it should leave. The bench sweeps every configuration code, every source with its enable and mask settings, and the standby override from each mode. It samples one edge after each stimulus, so a fault never waits more than one cycle to appear.

// File: rtl/subslp_pkg.sv
package subslp_pkg;

   typedef enum logic [1:0] {
      MODE_ACTIVE  = 2'b00,
      MODE_SUBSLP  = 2'b01,
      MODE_HWSTBY  = 2'b10
   } pmode_t;

   localparam int CFG_BITS = 3;

endpackage

// File: rtl/subslp_entry_qual.sv
module subslp_entry_qual
   import subslp_pkg::*;
#(
   parameter logic [CFG_BITS-1:0] ENTRY_CODE = 3'b011
) (
   input  logic                sleep_strobe,
   input  logic [CFG_BITS-1:0] cfg_bits,
   output logic                sleep_go,
   output logic                sleep_bad
);

   logic code_match;

   assign code_match = (cfg_bits == ENTRY_CODE);
   assign sleep_go   = sleep_strobe &  code_match;
   assign sleep_bad  = sleep_strobe & ~code_match;

endmodule

// File: rtl/subslp_wake_qual.sv
module subslp_wake_qual #(
   parameter int N_EXT = 13,
   parameter int N_INT = 8
) (
   input  logic [N_EXT-1:0] ext_req,
   input  logic [N_EXT-1:0] ext_en,
   input  logic [N_INT-1:0] int_req,
   input  logic [N_INT-1:0] int_en,
   input  logic             cpu_mask,
   output logic             wake_any
);

   logic [N_EXT-1:0] ext_hit;
   logic [N_INT-1:0] int_hit;

   for (genvar e = 0; e < N_EXT; e++) begin : g_ext
      assign ext_hit[e] = ext_req[e] & ext_en[e];
   end

   for (genvar p = 0; p < N_INT; p++) begin : g_int
      assign int_hit[p] = int_req[p] & int_en[p] & ~cpu_mask;
   end

   assign wake_any = (|ext_hit) | (|int_hit);

endmodule

// File: rtl/subslp_clk_map.sv
module subslp_clk_map
   import subslp_pkg::*;
#(
   parameter int                  N_PERIPH  = 16,
   parameter logic [N_PERIPH-1:0] KEEP_MASK = '0
) (
   input  pmode_t              cur_mode,
   output logic                cpu_clk_en,
   output logic [N_PERIPH-1:0] periph_clk_en,
   output logic                adc_clk_en,
   output logic                adc_retained
);

   logic is_active;
   logic is_subslp;

   assign is_active = (cur_mode == MODE_ACTIVE);
   assign is_subslp = (cur_mode == MODE_SUBSLP);

   for (genvar k = 0; k < N_PERIPH; k++) begin : g_periph
      if (KEEP_MASK[k]) begin : g_keep
         assign periph_clk_en[k] = is_active | is_subslp;
      end else begin : g_gate
         assign periph_clk_en[k] = is_active;
      end
   end

   assign cpu_clk_en   = is_active;
   assign adc_clk_en   = is_active;
   assign adc_retained = is_active;

endmodule

// File: rtl/subslp_ctrl.sv
module subslp_ctrl
   import subslp_pkg::*;
#(
   parameter int                  N_EXT     = 13,
   parameter int                  N_INT     = 8,
   parameter int                  N_PERIPH  = 16,
   parameter logic [N_PERIPH-1:0] KEEP_MASK = 16'h003F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                standby_req_n,
   input  logic                sleep_strobe,
   input  logic                cfg_stdby_sel,
   input  logic                cfg_lowspd_on,
   input  logic                cfg_wdt_subclk,
   input  logic [N_EXT-1:0]    ext_req,
   input  logic [N_EXT-1:0]    ext_en,
   input  logic [N_INT-1:0]    int_req,
   input  logic [N_INT-1:0]    int_en,
   input  logic                cpu_mask,
   output logic                cpu_clk_en,
   output logic [N_PERIPH-1:0] periph_clk_en,
   output logic                adc_clk_en,
   output logic                adc_retained,
   output logic                wake_pulse,
   output logic                sleep_reject,
   output logic [1:0]          mode
);

   localparam int N_SRC = N_EXT + N_INT;

   if (N_EXT < 1) begin : g_bad_ext
      $error("subslp_ctrl: N_EXT must be at least 1");
   end
   if (N_INT < 1) begin : g_bad_int
      $error("subslp_ctrl: N_INT must be at least 1");
   end
   if (N_PERIPH < 1) begin : g_bad_periph
      $error("subslp_ctrl: N_PERIPH must be at least 1");
   end
   if (N_SRC > 64) begin : g_bad_src
      $error("subslp_ctrl: too many wake sources");
   end

   pmode_t state_q, state_d;
   logic   sleep_go, sleep_bad, wake_any;
   logic   wake_d, reject_d;
   logic   wake_q, reject_q;

   subslp_entry_qual #(
      .ENTRY_CODE (3'b011)
   ) u_entry (
      .sleep_strobe (sleep_strobe),
      .cfg_bits     ({cfg_stdby_sel, cfg_lowspd_on, cfg_wdt_subclk}),
      .sleep_go     (sleep_go),
      .sleep_bad    (sleep_bad)
   );

   subslp_wake_qual #(
      .N_EXT (N_EXT),
      .N_INT (N_INT)
   ) u_wake (
      .ext_req  (ext_req),
      .ext_en   (ext_en),
      .int_req  (int_req),
      .int_en   (int_en),
      .cpu_mask (cpu_mask),
      .wake_any (wake_any)
   );

   always_comb begin
      state_d  = state_q;
      wake_d   = 1'b0;
      reject_d = 1'b0;
      if (!standby_req_n) begin
         state_d = MODE_HWSTBY;
      end else begin
         unique case (state_q)
            MODE_ACTIVE: begin
               if (sleep_go) begin
                  state_d = MODE_SUBSLP;
               end else if (sleep_bad) begin
                  reject_d = 1'b1;
               end
            end
            MODE_SUBSLP: begin
               if (wake_any) begin
                  state_d = MODE_ACTIVE;
                  wake_d  = 1'b1;
               end
            end
            MODE_HWSTBY: state_d = MODE_HWSTBY;
            default:     state_d = MODE_ACTIVE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= MODE_ACTIVE;
         wake_q   <= 1'b0;
         reject_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         wake_q   <= wake_d;
         reject_q <= reject_d;
      end
   end

   subslp_clk_map #(
      .N_PERIPH  (N_PERIPH),
      .KEEP_MASK (KEEP_MASK)
   ) u_clkmap (
      .cur_mode      (state_q),
      .cpu_clk_en    (cpu_clk_en),
      .periph_clk_en (periph_clk_en),
      .adc_clk_en    (adc_clk_en),
      .adc_retained  (adc_retained)
   );

   assign wake_pulse   = wake_q;
   assign sleep_reject = reject_q;
   assign mode         = state_q;

endmodule

// File: rtl/subslp_ctrl_chk.sv
module subslp_ctrl_chk #(
   parameter int                  N_EXT     = 13,
   parameter int                  N_INT     = 8,
   parameter int                  N_PERIPH  = 16,
   parameter logic [N_PERIPH-1:0] KEEP_MASK = 16'h003F
) (
   input logic                clk,
   input logic                rst_n,
   input logic                standby_req_n,
   input logic                sleep_strobe,
   input logic                cfg_stdby_sel,
   input logic                cfg_lowspd_on,
   input logic                cfg_wdt_subclk,
   input logic [N_EXT-1:0]    ext_req,
   input logic [N_EXT-1:0]    ext_en,
   input logic [N_INT-1:0]    int_req,
   input logic [N_INT-1:0]    int_en,
   input logic                cpu_mask,
   input logic                cpu_clk_en,
   input logic [N_PERIPH-1:0] periph_clk_en,
   input logic                adc_clk_en,
   input logic                adc_retained,
   input logic                wake_pulse,
   input logic                sleep_reject,
   input logic [1:0]          mode
);

   localparam logic [1:0] M_ACT = 2'b00;
   localparam logic [1:0] M_SUB = 2'b01;
   localparam logic [1:0] M_HWS = 2'b10;

   logic good_cfg;
   logic qual_wake;
   assign good_cfg  = !cfg_stdby_sel && cfg_lowspd_on && cfg_wdt_subclk;
   assign qual_wake = (|(ext_req & ext_en)) || ((|(int_req & int_en)) && !cpu_mask);

   assert_subslp_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ACT && standby_req_n && sleep_strobe && good_cfg) |=> (mode == M_SUB));

   assert_reject_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_reject |-> (mode == M_ACT && $past(mode) == M_ACT && $past(sleep_strobe)));

   assert_subslp_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SUB) |-> (!cpu_clk_en && !adc_clk_en && periph_clk_en == KEEP_MASK));

   assert_active_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ACT) |-> (cpu_clk_en && adc_clk_en && adc_retained && (&periph_clk_en)));

   assert_no_unqualified_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SUB && standby_req_n && !qual_wake) |=> (mode == M_SUB));

   assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cpu_clk_en && $past(mode) == M_SUB));

   assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_standby_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_req_n |=> (mode == M_HWS && !cpu_clk_en && !adc_clk_en && periph_clk_en == '0));

   assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_HWS) |=> (mode == M_HWS));

   assert_strobe_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SUB && standby_req_n && !qual_wake && sleep_strobe) |=> !sleep_reject);

   always_comb begin
      if (rst_n && mode == M_SUB) begin
         assert_adc_flag_R4: assert (!adc_retained);
      end
   end

endmodule

bind subslp_ctrl subslp_ctrl_chk #(
   .N_EXT     (N_EXT),
   .N_INT     (N_INT),
   .N_PERIPH  (N_PERIPH),
   .KEEP_MASK (KEEP_MASK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .standby_req_n (standby_req_n),
   .sleep_strobe  (sleep_strobe),
   .cfg_stdby_sel (cfg_stdby_sel),
   .cfg_lowspd_on (cfg_lowspd_on),
   .cfg_wdt_subclk(cfg_wdt_subclk),
   .ext_req       (ext_req),
   .ext_en        (ext_en),
   .int_req       (int_req),
   .int_en        (int_en),
   .cpu_mask      (cpu_mask),
   .cpu_clk_en    (cpu_clk_en),
   .periph_clk_en (periph_clk_en),
   .adc_clk_en    (adc_clk_en),
   .adc_retained  (adc_retained),
   .wake_pulse    (wake_pulse),
   .sleep_reject  (sleep_reject),
   .mode          (mode)
);

// File: tb/subslp_ctrl_test.sv
`timescale 1ns/1ps
module subslp_ctrl_test;

   localparam int                  NE   = 4;
   localparam int                  NI   = 3;
   localparam int                  NP   = 6;
   localparam logic [NP-1:0]       KEEP = 6'b010110;
   localparam int                  WATCHDOG_CYC = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          standby_req_n = 1'b1;
   logic          sleep_strobe = 1'b0;
   logic          cfg_stdby_sel = 1'b0;
   logic          cfg_lowspd_on = 1'b0;
   logic          cfg_wdt_subclk = 1'b0;
   logic [NE-1:0] ext_req = '0;
   logic [NE-1:0] ext_en = '0;
   logic [NI-1:0] int_req = '0;
   logic [NI-1:0] int_en = '0;
   logic          cpu_mask = 1'b0;
   logic          cpu_clk_en;
   logic [NP-1:0] periph_clk_en;
   logic          adc_clk_en;
   logic          adc_retained;
   logic          wake_pulse;
   logic          sleep_reject;
   logic [1:0]    mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   subslp_ctrl #(
      .N_EXT(NE), .N_INT(NI), .N_PERIPH(NP), .KEEP_MASK(KEEP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .standby_req_n(standby_req_n),
      .sleep_strobe(sleep_strobe), .cfg_stdby_sel(cfg_stdby_sel),
      .cfg_lowspd_on(cfg_lowspd_on), .cfg_wdt_subclk(cfg_wdt_subclk),
      .ext_req(ext_req), .ext_en(ext_en), .int_req(int_req), .int_en(int_en),
      .cpu_mask(cpu_mask), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .adc_clk_en(adc_clk_en), .adc_retained(adc_retained), .wake_pulse(wake_pulse),
      .sleep_reject(sleep_reject), .mode(mode)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check_outputs(input string req, input logic [1:0] m,
                                input bit wk, input bit rj);
      int exp_cpu, exp_per, exp_ret;
      exp_cpu = (m == 2'b00) ? 1 : 0;
      exp_ret = exp_cpu;
      exp_per = (m == 2'b00) ? int'({NP{1'b1}}) : (m == 2'b01) ? int'(KEEP) : 0;
      check(req, "mode", int'(mode), int'(m));
      check(req, "cpu_clk_en", int'(cpu_clk_en), exp_cpu);
      check(req, "adc_clk_en", int'(adc_clk_en), exp_cpu);
      check(req, "periph_clk_en", int'(periph_clk_en), exp_per);
      check(req, "adc_retained", int'(adc_retained), exp_ret);
      check(req, "wake_pulse", int'(wake_pulse), int'(wk));
      check(req, "sleep_reject", int'(sleep_reject), int'(rj));
   endtask

   task automatic enter_sub();
      {cfg_stdby_sel, cfg_lowspd_on, cfg_wdt_subclk} = 3'b011;
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      check("R1", "entry", int'(mode), 1);
   endtask

   task automatic leave_sub();
      ext_req = '0; ext_en = '0; int_req = '0; int_en = '0; cpu_mask = 1'b0;
      ext_req[0] = 1'b1; ext_en[0] = 1'b1;
      tick();
      ext_req = '0; ext_en = '0;
      check_outputs("R7", 2'b00, 1'b1, 1'b0);
      tick();
      check_outputs("R7", 2'b00, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #3;
      check_outputs("R10", 2'b00, 1'b0, 1'b0);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check_outputs("R10", 2'b00, 1'b0, 1'b0);

      // R1 R2: sweep all configuration codes
      for (int c = 0; c < 8; c++) begin
         {cfg_stdby_sel, cfg_lowspd_on, cfg_wdt_subclk} = c[2:0];
         sleep_strobe = 1'b1;
         tick();
         sleep_strobe = 1'b0;
         if (c == 3) begin
            check_outputs("R1", 2'b01, 1'b0, 1'b0);
            check_outputs("R3", 2'b01, 1'b0, 1'b0);
            // R11: strobe with any code ignored in sub-sleep
            {cfg_stdby_sel, cfg_lowspd_on, cfg_wdt_subclk} = 3'b100;
            sleep_strobe = 1'b1;
            tick();
            sleep_strobe = 1'b0;
            check_outputs("R11", 2'b01, 1'b0, 1'b0);
            leave_sub();
         end else begin
            check_outputs("R2", 2'b00, 1'b0, 1'b1);
            tick();
            check_outputs("R2", 2'b00, 1'b0, 1'b0);
         end
      end

      // R5: external sources, enable on and off
      for (int i = 0; i < NE; i++) begin
         for (int en = 0; en < 2; en++) begin
            enter_sub();
            ext_req = '0; ext_req[i] = 1'b1;
            ext_en = ~ext_req;
            if (en == 1) ext_en[i] = 1'b1;
            tick();
            ext_req = '0; ext_en = '0;
            if (en == 1) begin
               check_outputs("R5", 2'b00, 1'b1, 1'b0);
               tick();
               check_outputs("R7", 2'b00, 1'b0, 1'b0);
            end else begin
               check_outputs("R5", 2'b01, 1'b0, 1'b0);
               leave_sub();
            end
         end
      end

      // R6: peripheral sources, enable and mask combinations
      for (int i = 0; i < NI; i++) begin
         for (int k = 0; k < 4; k++) begin
            bit en, msk;
            en = k[0]; msk = k[1];
            enter_sub();
            int_req = '0; int_req[i] = 1'b1;
            int_en = ~int_req;
            if (en) int_en[i] = 1'b1;
            cpu_mask = msk;
            tick();
            int_req = '0; int_en = '0; cpu_mask = 1'b0;
            if (en && !msk) begin
               check_outputs("R6", 2'b00, 1'b1, 1'b0);
               tick();
               check_outputs("R7", 2'b00, 1'b0, 1'b0);
            end else begin
               check_outputs("R6", 2'b01, 1'b0, 1'b0);
               leave_sub();
            end
         end
      end

      // R8: standby wins over a qualified wake in sub-sleep
      enter_sub();
      ext_req[1] = 1'b1; ext_en[1] = 1'b1;
      standby_req_n = 1'b0;
      tick();
      check_outputs("R8", 2'b10, 1'b0, 1'b0);
      standby_req_n = 1'b1;
      // R9: stays in hardware standby with pin high, strobes and wakes present
      sleep_strobe = 1'b1;
      {cfg_stdby_sel, cfg_lowspd_on, cfg_wdt_subclk} = 3'b000;
      tick();
      sleep_strobe = 1'b0;
      check_outputs("R9", 2'b10, 1'b0, 1'b0);
      check_outputs("R11", 2'b10, 1'b0, 1'b0);
      tick(); tick();
      check_outputs("R9", 2'b10, 1'b0, 1'b0);
      ext_req = '0; ext_en = '0;
      rst_n = 1'b0;
      #1;
      check_outputs("R10", 2'b00, 1'b0, 1'b0);
      tick();
      rst_n = 1'b1;
      tick();
      check_outputs("R9", 2'b00, 1'b0, 1'b0);

      // R8: standby from active
      standby_req_n = 1'b0;
      tick();
      check_outputs("R8", 2'b10, 1'b0, 1'b0);
      // R9: reset with pin still low returns to standby after release
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      check_outputs("R9", 2'b10, 1'b0, 1'b0);
      standby_req_n = 1'b1;
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      check_outputs("R9", 2'b00, 1'b0, 1'b0);
      // R4: adc state flag follows the mode
      enter_sub();
      check("R4", "adc_retained in sub-sleep", int'(adc_retained), 0);
      leave_sub();
      check("R4", "adc_retained active", int'(adc_retained), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule